// File: doc/BRIEF.md
# Split-Issue ALU Execution Lane

This block is one arithmetic lane of a wide-instruction processor in which a single ALU operation is spread over two consecutive instruction words. In the issue cycle the lane takes two source register numbers and an opcode. It reads both operands from a 64 x 32-bit register file and stores them, together with the opcode, in a stage register that sits ahead of the ALU. In the following cycle the ALU works on the staged values. The result goes to the register named by the destination field of the word presented in that following cycle. The issuing word never waits for its own result.

Each instruction word therefore does two jobs. Its source and opcode fields start a new operation, and its destination field retires the operation started one word earlier. This lets software issue an operation on every cycle. A second write port stands in for results that come back from a neighbouring load lane. A combinational debug port shows the stored contents of any register.

Top module: `split_alu_slot`

## Requirements
- R1: After a synchronous reset, all 64 registers read zero on the debug port, and no register write happens in the first cycle after reset.
- R2: The opcodes (4-bit field) compute, modulo 2^32: 0 = A+B, 1 = A-B, 2 = A AND B, 3 = A OR B, 4 = A XOR B, 5 = A (pass the first source).
- R3: An operation issued by a valid word in cycle N appears on `res_data` in cycle N+1. At the end of cycle N+1 it is written to the register named by `in_dst` of the word presented in N+1, and `res_dst` shows that number.
- R4: Operand values are taken in the issue cycle. A later change to a source register does not alter the result of an operation that has already been issued.
- R5: Opcodes 6 to 15 perform no write in the following cycle, whatever the destination field holds.
- R6: When the issuing word has `in_valid` low, no register is written in the next cycle, whatever that word's destination field holds.
- R7: When the word that supplies the destination has `in_valid` low, the pending result is dropped and no register is written.
- R8: A source register that is being written in the same cycle (by the ALU result or by the load port) is read with its new value.
- R9: The load port writes `ld_data` into `ld_addr` at the clock edge. If the ALU writes the same register in the same cycle, the ALU value is stored.
- R10: Operations may be issued back to back. Each word retires the previous operation and starts the next one without a lost cycle.
- R11: `dbg_data` shows the stored contents of `dbg_addr` combinationally. It shows the value from before any write that is pending in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Current instruction word is valid |
| in_src_a | input | 6 | First source register number |
| in_src_b | input | 6 | Second source register number |
| in_op | input | 4 | Opcode of the operation being issued |
| in_dst | input | 6 | Destination for the previously issued operation |
| ld_en | input | 1 | Load-lane write enable |
| ld_addr | input | 6 | Load-lane destination register |
| ld_data | input | 32 | Load-lane write data |
| dbg_addr | input | 6 | Debug read register number |
| dbg_data | output | 32 | Stored contents of `dbg_addr` |
| res_valid | output | 1 | ALU result is written this cycle |
| res_dst | output | 6 | Register receiving the ALU result |
| res_data | output | 32 | ALU result of the staged operation |

## Verification
The assertions check the write-enable rules on every cycle. No write may follow an invalid issuing word, a no-op opcode or reset. No write may happen while the current word is invalid. The stage valid bit must track the previous cycle's `in_valid`. The bench scenarios are needed to show the data side: the arithmetic of each opcode, the register that receives a result, operand capture at issue time, same-cycle bypassing, and the priority between the ALU and the load port. They read results back through the debug port.

// File: rtl/split_alu_pkg.sv
package split_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_PASS = 4'd5
  } alu_op_e;

  // True when the opcode produces a result that is written back.
  function automatic logic op_writes(input logic [OP_W-1:0] op);
    return op <= OP_W'(OP_PASS);
  endfunction
endpackage

// File: rtl/slot_regfile.sv
module slot_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 64,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_we,
  input  logic [AW-1:0]     alu_wa,
  input  logic [DATA_W-1:0] alu_wd,
  input  logic              ld_we,
  input  logic [AW-1:0]     ld_wa,
  input  logic [DATA_W-1:0] ld_wd,
  input  logic [AW-1:0]     ra0,
  input  logic [AW-1:0]     ra1,
  input  logic [AW-1:0]     dbg_ra,
  output logic [DATA_W-1:0] rd0,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] dbg_rd,
  output logic              byp0_hit,
  output logic              byp1_hit
);
  logic [DATA_W-1:0] mem [NREG];

  // Read-through: the value a register will hold after this edge.
  function automatic logic [DATA_W-1:0] fwd(input logic [AW-1:0] a,
                                            input logic [DATA_W-1:0] stored);
    if (alu_we && alu_wa == a)     return alu_wd;
    else if (ld_we && ld_wa == a)  return ld_wd;
    else                           return stored;
  endfunction

  assign rd0      = fwd(ra0, mem[ra0]);
  assign rd1      = fwd(ra1, mem[ra1]);
  assign byp0_hit = (alu_we && alu_wa == ra0) || (ld_we && ld_wa == ra0);
  assign byp1_hit = (alu_we && alu_wa == ra1) || (ld_we && ld_wa == ra1);
  assign dbg_rd   = mem[dbg_ra];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      if (ld_we)  mem[ld_wa]  <= ld_wd;
      if (alu_we) mem[alu_wa] <= alu_wd;  // later assignment wins
    end
  end
endmodule

// File: rtl/slot_issue_reg.sv
module slot_issue_reg #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_a,
  input  logic [DATA_W-1:0] iss_b,
  output logic              st_valid,
  output logic [OP_W-1:0]   st_op,
  output logic [DATA_W-1:0] st_a,
  output logic [DATA_W-1:0] st_b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_op    <= '0;
      st_a     <= '0;
      st_b     <= '0;
    end else begin
      st_valid <= iss_valid;
      st_op    <= iss_op;
      st_a     <= iss_a;
      st_b     <= iss_b;
    end
  end
endmodule

// File: rtl/slot_alu.sv
module slot_alu
  import split_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              writes
);
  function automatic logic [DATA_W-1:0] compute(input logic [OP_W-1:0] f,
                                                input logic [DATA_W-1:0] x,
                                                input logic [DATA_W-1:0] z);
    case (f)
      OP_ADD:  return x + z;
      OP_SUB:  return x - z;
      OP_AND:  return x & z;
      OP_OR:   return x | z;
      OP_XOR:  return x ^ z;
      OP_PASS: return x;
      default: return '0;
    endcase
  endfunction

  assign y      = compute(op, a, b);
  assign writes = op_writes(op);
endmodule

// File: rtl/split_alu_slot.sv
module split_alu_slot
  import split_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 64,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [AW-1:0]     in_src_a,
  input  logic [AW-1:0]     in_src_b,
  input  logic [OP_W-1:0]   in_op,
  input  logic [AW-1:0]     in_dst,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [AW-1:0]     dbg_addr,
  output logic [DATA_W-1:0] dbg_data,
  output logic              res_valid,
  output logic [AW-1:0]     res_dst,
  output logic [DATA_W-1:0] res_data
);
  // Named internal events, brought out for the checker.
  logic              st_valid;
  logic [OP_W-1:0]   st_op;
  logic [DATA_W-1:0] st_a, st_b;
  logic [DATA_W-1:0] opnd_a, opnd_b;
  logic [DATA_W-1:0] alu_y;
  logic              alu_writes;
  logic              wb_fire;
  logic              byp_a_hit, byp_b_hit;

  slot_alu #(.DATA_W(DATA_W)) u_alu (
    .op(st_op), .a(st_a), .b(st_b), .y(alu_y), .writes(alu_writes)
  );

  // The retiring word must be valid to give a meaningful destination.
  assign wb_fire = st_valid && in_valid && alu_writes;

  slot_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .alu_we(wb_fire), .alu_wa(in_dst), .alu_wd(alu_y),
    .ld_we(ld_en), .ld_wa(ld_addr), .ld_wd(ld_data),
    .ra0(in_src_a), .ra1(in_src_b), .dbg_ra(dbg_addr),
    .rd0(opnd_a), .rd1(opnd_b), .dbg_rd(dbg_data),
    .byp0_hit(byp_a_hit), .byp1_hit(byp_b_hit)
  );

  slot_issue_reg #(.DATA_W(DATA_W), .OP_W(OP_W)) u_stage (
    .clk(clk), .rst(rst),
    .iss_valid(in_valid), .iss_op(in_op), .iss_a(opnd_a), .iss_b(opnd_b),
    .st_valid(st_valid), .st_op(st_op), .st_a(st_a), .st_b(st_b)
  );

  assign res_valid = wb_fire;
  assign res_dst   = in_dst;
  assign res_data  = alu_y;
endmodule

// File: rtl/split_alu_slot_chk.sv
module split_alu_slot_chk #(
  parameter int OP_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [OP_W-1:0] in_op,
  input logic            res_valid,
  input logic            st_valid
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid);

  a_r5_nop_no_write: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_op > 4'd5) |-> !res_valid);

  a_r6_invalid_issue_no_write: assert property (@(posedge clk) disable iff (rst)
    $past(!in_valid) |-> !res_valid);

  a_r7_invalid_word_no_write: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !res_valid);

  a_r3_stage_tracks_issue: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (st_valid == $past(in_valid)));
endmodule

bind split_alu_slot split_alu_slot_chk #(.OP_W(4)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
  .res_valid(res_valid), .st_valid(st_valid)
);

// File: tb/tb_split_alu_slot.sv
module tb_split_alu_slot;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  in_src_a = '0, in_src_b = '0, in_dst = '0;
  logic [3:0]  in_op = '0;
  logic        ld_en = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [5:0]  dbg_addr = '0;
  logic [31:0] dbg_data, res_data;
  logic        res_valid;
  logic [5:0]  res_dst;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_alu_slot dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_op(in_op), .in_dst(in_dst), .ld_en(ld_en),
    .ld_addr(ld_addr), .ld_data(ld_data), .dbg_addr(dbg_addr),
    .dbg_data(dbg_data), .res_valid(res_valid), .res_dst(res_dst),
    .res_data(res_data)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Drive one word; the caller then checks, then calls tick.
  task automatic word(input logic v, input logic [5:0] a, input logic [5:0] b,
                      input logic [3:0] op, input logic [5:0] dst);
    in_valid = v; in_src_a = a; in_src_b = b; in_op = op; in_dst = dst;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic logic [31:0] peek(input logic [5:0] r);
    return 32'h0;
  endfunction

  task automatic rd(input string req, input logic [5:0] r, input logic [31:0] exp);
    dbg_addr = r; #1;
    chk(req, dbg_data, exp);
  endtask

  task automatic load(input logic [5:0] r, input logic [31:0] d);
    word(1'b0, 0, 0, 4'd0, 0);
    ld_en = 1'b1; ld_addr = r; ld_data = d;
    tick();
  endtask

  task automatic t_reset();
    logic bad = 1'b0;
    for (int i = 0; i < 64; i++) begin
      dbg_addr = 6'(i); #1;
      if (dbg_data !== 32'h0) bad = 1'b1;
    end
    chk("R1 all registers zero", {31'h0, bad}, 32'h0);
    word(1'b1, 0, 0, 4'd0, 6'd9);
    chk("R1 no write first cycle", {31'h0, res_valid}, 32'h0);
    tick();
    word(1'b0, 0, 0, 4'd0, 6'd0);
    tick();
  endtask

  task automatic t_ops();
    load(6'd1, 32'd100);
    load(6'd2, 32'd30);
    word(1'b1, 1, 2, 4'd0, 6'd0);
    chk("R3 nothing staged yet", {31'h0, res_valid}, 32'h0);
    tick();
    word(1'b1, 1, 2, 4'd1, 6'd10);
    chk("R2 add result", res_data, 32'd130);
    chk("R3 write valid", {31'h0, res_valid}, 32'h1);
    chk("R3 dst from next word", {26'h0, res_dst}, 32'd10);
    dbg_addr = 6'd10; #1;
    chk("R11 debug shows old value", dbg_data, 32'd0);
    tick();
    word(1'b1, 1, 2, 4'd2, 6'd11); chk("R2 sub", res_data, 32'd70); tick();
    word(1'b1, 1, 2, 4'd3, 6'd12); chk("R2 and", res_data, 32'd4); tick();
    word(1'b1, 1, 2, 4'd4, 6'd13); chk("R2 or", res_data, 32'd126); tick();
    word(1'b1, 1, 2, 4'd5, 6'd14); chk("R2 xor", res_data, 32'd122); tick();
    word(1'b1, 2, 1, 4'd1, 6'd15); chk("R2 pass", res_data, 32'd100); tick();
    word(1'b1, 1, 2, 4'd9, 6'd16); chk("R2 sub wraps", res_data, 32'hFFFFFFBA); tick();
    word(1'b1, 0, 0, 4'd0, 6'd17);
    chk("R5 nop opcode no write", {31'h0, res_valid}, 32'h0);
    tick();
    word(1'b0, 0, 0, 4'd0, 6'd0); tick();
    rd("R10 r10", 6'd10, 32'd130);
    rd("R10 r11", 6'd11, 32'd70);
    rd("R10 r12", 6'd12, 32'd4);
    rd("R10 r13", 6'd13, 32'd126);
    rd("R10 r14", 6'd14, 32'd122);
    rd("R10 r15", 6'd15, 32'd100);
    rd("R2 r16 wrap", 6'd16, 32'hFFFFFFBA);
    rd("R5 r17 untouched", 6'd17, 32'd0);
  endtask

  task automatic t_invalid();
    word(1'b0, 1, 2, 4'd0, 6'd0); tick();
    word(1'b1, 0, 0, 4'd7, 6'd20);
    chk("R6 invalid issue no write", {31'h0, res_valid}, 32'h0);
    tick();
    word(1'b1, 1, 2, 4'd0, 6'd0); tick();
    word(1'b0, 0, 0, 4'd7, 6'd21);
    chk("R7 invalid word no write", {31'h0, res_valid}, 32'h0);
    tick();
    word(1'b0, 0, 0, 4'd0, 6'd0); tick();
    rd("R6 r20 untouched", 6'd20, 32'd0);
    rd("R7 r21 untouched", 6'd21, 32'd0);
  endtask

  task automatic t_capture();
    word(1'b1, 1, 2, 4'd0, 6'd0); tick();
    word(1'b1, 0, 0, 4'd7, 6'd22);
    ld_en = 1'b1; ld_addr = 6'd1; ld_data = 32'd5;
    tick();
    word(1'b0, 0, 0, 4'd0, 6'd0); tick();
    rd("R4 result from issue-time operands", 6'd22, 32'd130);
    rd("R9 load stored", 6'd1, 32'd5);
  endtask

  task automatic t_bypass();
    word(1'b1, 1, 2, 4'd0, 6'd0); tick();           // 5 + 30
    word(1'b1, 3, 2, 4'd0, 6'd3); tick();           // r3 <= 35, reads r3 bypassed
    word(1'b1, 0, 4, 4'd7, 6'd23);
    chk("R8 ALU bypass", res_data, 32'd65);
    tick();
    word(1'b1, 4, 0, 4'd5, 6'd0);
    ld_en = 1'b1; ld_addr = 6'd4; ld_data = 32'd7;
    tick();
    word(1'b1, 0, 0, 4'd7, 6'd24);
    chk("R8 load bypass", res_data, 32'd7);
    tick();
    word(1'b0, 0, 0, 4'd0, 6'd0); tick();
    rd("R8 r23", 6'd23, 32'd65);
    rd("R8 r24", 6'd24, 32'd7);
  endtask

  task automatic t_priority();
    word(1'b1, 1, 2, 4'd0, 6'd0); tick();           // 35
    word(1'b1, 0, 0, 4'd7, 6'd25);
    ld_en = 1'b1; ld_addr = 6'd25; ld_data = 32'd999;
    tick();
    word(1'b0, 0, 0, 4'd0, 6'd0); tick();
    rd("R9 ALU wins over load", 6'd25, 32'd35);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ops();
    t_invalid();
    t_capture();
    t_bypass();
    t_priority();
    finish_run();
  end
endmodule